// File: doc/BRIEF.md
# Sleep-Mode Clock Controller

This block watches the instruction stream of a small CPU core and puts the chip into one of two sleep depths when the matching opcode is executed. In the shallow depth (halt) only the CPU clock is gated: the oscillator and the peripheral clock keep running, so the counter/timers and the interrupt inputs stay live. In the deep depth (stop) the CPU clock, the peripheral clock and the oscillator are all switched off. A sleep opcode is honoured only when a pipeline-flush NOP was the instruction executed just before it. A sleep opcode that breaks this rule sets a sticky error flag and then behaves as a NOP.

Waking differs between the depths. Halt ends when any interrupt request arrives whose enable bit is set. The CPU then resumes in place, and a one-cycle resume pulse is raised. Stop ignores interrupts and ends only on one of four reset sources: watchdog expiry, power-on, stop recovery or external reset. On that exit the block raises a one-cycle restart request with a fixed restart address of 000Ch. The same reset sources also restart the core from run or halt.

States and transitions: RUN (00), HALT (01), STOP (10).
- RUN to HALT: an accepted halt opcode with no enabled interrupt pending.
- RUN to STOP: an accepted stop opcode.
- HALT to RUN: an enabled interrupt (resume), or a reset source (restart).
- STOP to RUN: a reset source only (restart).
- RUN to RUN: a reset source (restart), a blocked halt, or any other instruction.

Top module: `sleep_mode_ctrl`

## Requirements
- R1: After rst_n is released: mode_o = 00 (RUN), cpu_clk_en = 1, osc_en = 1, periph_clk_en = 1, sleep_err = 0, restart_req = 0, halt_resume = 0.
- R2: A valid halt opcode (7Fh) whose previous valid instruction was the NOP (FFh), with no enabled interrupt pending, gives mode_o = 01 from the next cycle: cpu_clk_en = 0, osc_en = 1, periph_clk_en = 1.
- R3: A valid stop opcode (6Fh) whose previous valid instruction was FFh gives mode_o = 10 from the next cycle: cpu_clk_en, osc_en and periph_clk_en all 0.
- R4: A sleep opcode whose previous valid instruction was not FFh leaves the mode at RUN and sets sleep_err. sleep_err then holds until rst_n. The same opcode counts as a NOP, so a sleep opcode that follows it directly is accepted. The first instruction after reset or after a wake never counts as preceded by a NOP.
- R5: In HALT, a cycle with (irq_req & irq_en) nonzero returns mode_o to 00 in the next cycle. halt_resume is high for exactly that one cycle and restart_req stays 0. Requests whose enable bit is clear do not wake.
- R6: An accepted halt opcode in a cycle where (irq_req & irq_en) is nonzero does not enter HALT: the mode stays 00 and sleep_err is not set.
- R7: In STOP, interrupts and instructions have no effect. Any of wdt_trip, power_on_evt, stop_recover or ext_reset_evt returns mode_o to 00 in the next cycle, with restart_req high for one cycle and restart_vec = 000Ch.
- R8: A reset source seen in RUN or HALT also gives mode_o = 00 with a one-cycle restart_req. It takes priority over a sleep opcode or an interrupt in the same cycle, and it clears the NOP history.
- R9: Cycles with instr_valid = 0 neither change the mode nor break the NOP-to-sleep adjacency. Instructions presented outside RUN are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low reset of the controller |
| instr_valid | input | 1 | An instruction executes this cycle |
| instr_op | input | 8 | Opcode of that instruction |
| irq_req | input | 5 | Interrupt requests |
| irq_en | input | 5 | Per-request enable bits |
| wdt_trip | input | 1 | Watchdog expiry reset source |
| power_on_evt | input | 1 | Power-on reset source |
| stop_recover | input | 1 | Stop-recovery reset source |
| ext_reset_evt | input | 1 | External reset source |
| mode_o | output | 2 | Current mode: 00 RUN, 01 HALT, 10 STOP |
| cpu_clk_en | output | 1 | CPU core clock enable |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Timer and interrupt-logic clock enable |
| sleep_err | output | 1 | Sticky flag: sleep opcode without preceding NOP |
| restart_req | output | 1 | One-cycle pulse: restart at restart_vec |
| restart_vec | output | 12 | Restart address, 000Ch |
| halt_resume | output | 1 | One-cycle pulse: left HALT on an interrupt |

## Verification
Directed sequences cover several distinct cases, each separating a different pair of outcomes:
- A NOP directly before each sleep opcode, versus a different opcode directly before it (accept versus error).
- A gap of invalid cycles inside the NOP-to-sleep pair (adjacency counts only valid instructions).
- A request with its enable clear, versus a request with its enable set (no wake versus halt wake).
- An enabled request in the very cycle of the halt opcode (blocked entry).
- A reset source together with a sleep opcode (priority of the restart).

Long random streams of weighted opcodes, sparse interrupts and rare reset sources are then compared every cycle against a bench model of the mode, the NOP history and the error flag. This catches mistakes in ordering and history that the directed cases miss.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_HALT = 2'b01,
        MODE_STOP = 2'b10
    } pm_mode_e;

    localparam int unsigned N_RESET_SRC = 4;

endpackage

// File: rtl/pm_opcode_track.sv
module pm_opcode_track #(
    parameter int unsigned OP_W    = 8,
    parameter logic [OP_W-1:0] NOP_OP  = 8'hFF,
    parameter logic [OP_W-1:0] HALT_OP = 8'h7F,
    parameter logic [OP_W-1:0] STOP_OP = 8'h6F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [OP_W-1:0] instr_op,
    input  logic            accept,
    input  logic            flush,
    output logic            halt_ok,
    output logic            stop_ok,
    output logic            sleep_err
);

    logic prev_nop_q;
    logic err_q;
    logic exec;
    logic is_nop;
    logic is_halt;
    logic is_stop;
    logic bad_sleep;

    assign exec      = accept && instr_valid;
    assign is_nop    = (instr_op == NOP_OP);
    assign is_halt   = (instr_op == HALT_OP);
    assign is_stop   = (instr_op == STOP_OP);
    assign bad_sleep = exec && (is_halt || is_stop) && !prev_nop_q;
    assign halt_ok   = exec && is_halt && prev_nop_q;
    assign stop_ok   = exec && is_stop && prev_nop_q;
    assign sleep_err = err_q;

    // NOP history: set by an executed NOP or by a rejected sleep opcode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_nop_q <= 1'b0;
        end else if (flush) begin
            prev_nop_q <= 1'b0;
        end else if (exec) begin
            prev_nop_q <= is_nop || bad_sleep;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (bad_sleep) begin
            err_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pm_wake_src.sv
module pm_wake_src #(
    parameter int unsigned N_IRQ = 5,
    parameter int unsigned N_SRC = 4
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_SRC-1:0] reset_src,
    output logic             irq_wake,
    output logic             reset_wake
);

    logic [N_IRQ-1:0] live;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_gate
        assign live[i] = irq_req[i] & irq_en[i];
    end

    assign irq_wake   = |live;
    assign reset_wake = |reset_src;

endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
    import sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_ok,
    input  logic       stop_ok,
    input  logic       irq_wake,
    input  logic       reset_wake,
    output logic [1:0] mode,
    output logic       in_run,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic       periph_clk_en,
    output logic       restart_req,
    output logic       halt_resume
);

    pm_mode_e state_q;
    pm_mode_e state_d;
    logic     restart_d;
    logic     resume_d;
    logic     restart_q;
    logic     resume_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // pulse registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
            resume_q  <= 1'b0;
        end else begin
            restart_q <= restart_d;
            resume_q  <= resume_d;
        end
    end

    // transitions
    always_comb begin
        state_d   = state_q;
        restart_d = 1'b0;
        resume_d  = 1'b0;
        unique case (state_q)
            MODE_RUN: begin
                if (reset_wake) begin
                    restart_d = 1'b1;
                end else if (stop_ok) begin
                    state_d = MODE_STOP;
                end else if (halt_ok && !irq_wake) begin
                    state_d = MODE_HALT;
                end
            end
            MODE_HALT: begin
                if (reset_wake) begin
                    state_d   = MODE_RUN;
                    restart_d = 1'b1;
                end else if (irq_wake) begin
                    state_d  = MODE_RUN;
                    resume_d = 1'b1;
                end
            end
            MODE_STOP: begin
                if (reset_wake) begin
                    state_d   = MODE_RUN;
                    restart_d = 1'b1;
                end
            end
            default: begin
                state_d = MODE_RUN;
            end
        endcase
    end

    // outputs
    always_comb begin
        cpu_clk_en    = 1'b1;
        osc_en        = 1'b1;
        periph_clk_en = 1'b1;
        unique case (state_q)
            MODE_RUN: begin
                cpu_clk_en = 1'b1;
            end
            MODE_HALT: begin
                cpu_clk_en = 1'b0;
            end
            MODE_STOP: begin
                cpu_clk_en    = 1'b0;
                osc_en        = 1'b0;
                periph_clk_en = 1'b0;
            end
            default: begin
                cpu_clk_en = 1'b1;
            end
        endcase
    end

    assign mode        = state_q;
    assign in_run      = (state_q == MODE_RUN);
    assign restart_req = restart_q;
    assign halt_resume = resume_q;

endmodule

// File: rtl/sleep_mode_ctrl.sv
module sleep_mode_ctrl #(
    parameter int unsigned N_IRQ = 5,
    parameter int unsigned OP_W  = 8,
    parameter int unsigned VEC_W = 12,
    parameter logic [VEC_W-1:0] RESTART_ADDR = 12'h00C,
    parameter logic [OP_W-1:0]  NOP_OP  = 8'hFF,
    parameter logic [OP_W-1:0]  HALT_OP = 8'h7F,
    parameter logic [OP_W-1:0]  STOP_OP = 8'h6F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [OP_W-1:0]  instr_op,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_trip,
    input  logic             power_on_evt,
    input  logic             stop_recover,
    input  logic             ext_reset_evt,
    output logic [1:0]       mode_o,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             periph_clk_en,
    output logic             sleep_err,
    output logic             restart_req,
    output logic [VEC_W-1:0] restart_vec,
    output logic             halt_resume
);

    localparam int unsigned N_SRC = sleep_pkg::N_RESET_SRC;

    logic [N_SRC-1:0] reset_src;
    logic             irq_wake;
    logic             reset_wake;
    logic             halt_ok;
    logic             stop_ok;
    logic             in_run;
    logic             accept;

    assign reset_src = {ext_reset_evt, stop_recover, power_on_evt, wdt_trip};
    assign accept    = in_run && !reset_wake;

    pm_wake_src #(
        .N_IRQ(N_IRQ),
        .N_SRC(N_SRC)
    ) u_wake (
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .reset_src (reset_src),
        .irq_wake  (irq_wake),
        .reset_wake(reset_wake)
    );

    pm_opcode_track #(
        .OP_W   (OP_W),
        .NOP_OP (NOP_OP),
        .HALT_OP(HALT_OP),
        .STOP_OP(STOP_OP)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_valid(instr_valid),
        .instr_op   (instr_op),
        .accept     (accept),
        .flush      (reset_wake),
        .halt_ok    (halt_ok),
        .stop_ok    (stop_ok),
        .sleep_err  (sleep_err)
    );

    pm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_ok      (halt_ok),
        .stop_ok      (stop_ok),
        .irq_wake     (irq_wake),
        .reset_wake   (reset_wake),
        .mode         (mode_o),
        .in_run       (in_run),
        .cpu_clk_en   (cpu_clk_en),
        .osc_en       (osc_en),
        .periph_clk_en(periph_clk_en),
        .restart_req  (restart_req),
        .halt_resume  (halt_resume)
    );

    assign restart_vec = RESTART_ADDR;

endmodule

// File: rtl/sleep_mode_ctrl_chk.sv
module sleep_mode_ctrl_chk #(
    parameter int unsigned N_IRQ = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IRQ-1:0] irq_req,
    input logic [N_IRQ-1:0] irq_en,
    input logic             wdt_trip,
    input logic             power_on_evt,
    input logic             stop_recover,
    input logic             ext_reset_evt,
    input logic [1:0]       mode_o,
    input logic             cpu_clk_en,
    input logic             osc_en,
    input logic             periph_clk_en,
    input logic             sleep_err,
    input logic             restart_req,
    input logic             halt_resume
);

    logic any_src;
    assign any_src = wdt_trip | power_on_evt | stop_recover | ext_reset_evt;

    // R1
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);

    // R2
    halt_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01) |-> (!cpu_clk_en && osc_en && periph_clk_en));

    // R3
    stop_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> (!cpu_clk_en && !osc_en && !periph_clk_en));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_err |=> sleep_err);

    // R5
    halt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && (|(irq_req & irq_en)) && !any_src)
        |=> (mode_o == 2'b00 && halt_resume && !restart_req));

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10 && !any_src) |=> (mode_o == 2'b10));

    // R7
    stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10 && any_src) |=> (mode_o == 2'b00 && restart_req));

    // R8
    src_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_src |=> (mode_o == 2'b00 && restart_req && !halt_resume));

endmodule

bind sleep_mode_ctrl sleep_mode_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_req      (irq_req),
    .irq_en       (irq_en),
    .wdt_trip     (wdt_trip),
    .power_on_evt (power_on_evt),
    .stop_recover (stop_recover),
    .ext_reset_evt(ext_reset_evt),
    .mode_o       (mode_o),
    .cpu_clk_en   (cpu_clk_en),
    .osc_en       (osc_en),
    .periph_clk_en(periph_clk_en),
    .sleep_err    (sleep_err),
    .restart_req  (restart_req),
    .halt_resume  (halt_resume)
);

// File: tb/tb_sleep_mode_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_mode_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [7:0]  instr_op = 8'h00;
    logic [4:0]  irq_req = '0;
    logic [4:0]  irq_en = '0;
    logic        wdt_trip = 1'b0;
    logic        power_on_evt = 1'b0;
    logic        stop_recover = 1'b0;
    logic        ext_reset_evt = 1'b0;
    logic [1:0]  mode_o;
    logic        cpu_clk_en;
    logic        osc_en;
    logic        periph_clk_en;
    logic        sleep_err;
    logic        restart_req;
    logic [11:0] restart_vec;
    logic        halt_resume;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [1:0] m_mode = 2'b00;
    logic       m_prev = 1'b0;
    logic       m_err  = 1'b0;
    logic       m_rst  = 1'b0;
    logic       m_hw   = 1'b0;
    string      why    = "R1";

    always #5 clk = ~clk;

    sleep_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .irq_req(irq_req), .irq_en(irq_en), .wdt_trip(wdt_trip),
        .power_on_evt(power_on_evt), .stop_recover(stop_recover),
        .ext_reset_evt(ext_reset_evt), .mode_o(mode_o), .cpu_clk_en(cpu_clk_en),
        .osc_en(osc_en), .periph_clk_en(periph_clk_en), .sleep_err(sleep_err),
        .restart_req(restart_req), .restart_vec(restart_vec), .halt_resume(halt_resume)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic check_all();
        chk({30'd0, mode_o}, {30'd0, m_mode}, {why, " mode"});
        chk({31'd0, cpu_clk_en}, {31'd0, (m_mode == 2'b00)}, {why, " cpu_clk_en"});
        chk({31'd0, osc_en}, {31'd0, (m_mode != 2'b10)}, {why, " osc_en"});
        chk({31'd0, periph_clk_en}, {31'd0, (m_mode != 2'b10)}, {why, " periph_clk_en"});
        chk({31'd0, sleep_err}, {31'd0, m_err}, {why, " sleep_err (R4)"});
        chk({31'd0, restart_req}, {31'd0, m_rst}, {why, " restart_req"});
        chk({31'd0, halt_resume}, {31'd0, m_hw}, {why, " halt_resume (R5)"});
        if (m_rst) chk({20'd0, restart_vec}, 32'h00C, "R7 restart_vec");
    endtask

    // one clock of stimulus, model update and check
    task automatic step(input logic v, input logic [7:0] op, input logic [4:0] rq,
                        input logic [4:0] en, input logic [3:0] src);
        logic any;
        logic wk;
        instr_valid   = v;
        instr_op      = op;
        irq_req       = rq;
        irq_en        = en;
        wdt_trip      = src[0];
        power_on_evt  = src[1];
        stop_recover  = src[2];
        ext_reset_evt = src[3];
        any  = |src;
        wk   = |(rq & en);
        m_rst = 1'b0;
        m_hw  = 1'b0;
        why   = "R9";
        case (m_mode)
            2'b00: begin
                if (any) begin
                    m_rst = 1'b1; m_prev = 1'b0; why = "R8";
                end else if (v) begin
                    if (op == 8'h7F || op == 8'h6F) begin
                        if (m_prev) begin
                            m_prev = 1'b0;
                            if (op == 8'h6F) begin
                                m_mode = 2'b10; why = "R3";
                            end else if (!wk) begin
                                m_mode = 2'b01; why = "R2";
                            end else begin
                                why = "R6";
                            end
                        end else begin
                            m_err = 1'b1; m_prev = 1'b1; why = "R4";
                        end
                    end else begin
                        m_prev = (op == 8'hFF);
                    end
                end
            end
            2'b01: begin
                if (any) begin
                    m_mode = 2'b00; m_rst = 1'b1; m_prev = 1'b0; why = "R8";
                end else if (wk) begin
                    m_mode = 2'b00; m_hw = 1'b1; m_prev = 1'b0; why = "R5";
                end else begin
                    why = "R5";
                end
            end
            default: begin
                why = "R7";
                if (any) begin
                    m_mode = 2'b00; m_rst = 1'b1; m_prev = 1'b0;
                end
            end
        endcase
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] op;
        logic [4:0] rq;
        logic [3:0] src;
        int r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        why = "R1";
        check_all();

        // directed corners
        step(1, 8'hFF, 0, 0, 0);            // R9 plain NOP
        step(1, 8'h7F, 0, 0, 0);            // R2 enter HALT
        step(0, 8'h00, 5'h01, 5'h00, 0);    // R5 request without enable
        step(1, 8'hFF, 5'h04, 5'h04, 0);    // R5 enabled wake
        step(1, 8'hFF, 0, 0, 0);
        step(1, 8'h6F, 0, 0, 0);            // R3 enter STOP
        step(0, 8'h00, 5'h1F, 5'h1F, 0);    // R7 interrupts ignored
        step(1, 8'hFF, 0, 0, 0);            // R7 instruction ignored
        step(1, 8'h7F, 0, 0, 0);            // R7 still STOP
        step(0, 8'h00, 0, 0, 4'b0001);      // R7 watchdog restart
        step(1, 8'h7F, 0, 0, 0);            // R4 no NOP after wake
        step(1, 8'h7F, 0, 0, 0);            // R4 previous counted as NOP
        step(0, 8'h00, 5'h10, 5'h10, 0);
        step(1, 8'h00, 0, 0, 0);
        step(1, 8'h6F, 0, 0, 0);            // R4 rejected again
        step(1, 8'h12, 0, 0, 0);
        step(1, 8'hFF, 0, 0, 0);
        step(0, 8'h7F, 0, 0, 0);            // R9 invalid slot
        step(0, 8'h00, 0, 0, 0);            // R9 gap
        step(1, 8'h7F, 0, 0, 0);            // R9 adjacency kept
        step(0, 8'h00, 5'h02, 5'h02, 0);
        step(1, 8'hFF, 0, 0, 0);
        step(1, 8'h7F, 5'h08, 5'h08, 0);    // R6 blocked entry
        step(1, 8'hFF, 0, 0, 0);
        step(1, 8'h6F, 0, 0, 4'b1000);      // R8 reset beats STOP
        step(1, 8'h6F, 0, 0, 0);            // R8 history cleared
        step(1, 8'hFF, 0, 0, 0);
        step(1, 8'h7F, 0, 0, 0);
        step(0, 8'h00, 5'h01, 5'h01, 4'b0010); // R8 reset beats wake in HALT
        step(1, 8'hFF, 0, 0, 0);
        step(1, 8'h6F, 0, 0, 0);
        step(0, 8'h00, 0, 0, 4'b0100);      // R7 stop recovery
        step(1, 8'hFF, 0, 0, 0);
        step(1, 8'h6F, 0, 0, 0);
        step(0, 8'h00, 0, 0, 4'b0010);      // R7 power-on

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            r = $urandom % 8;
            if (r < 3)       op = 8'hFF;
            else if (r == 3) op = 8'h7F;
            else if (r == 4) op = 8'h6F;
            else             op = 8'($urandom);
            rq  = ($urandom % 6 == 0) ? 5'($urandom) : 5'd0;
            src = ($urandom % 50 == 0) ? 4'(1 << ($urandom % 4)) : 4'd0;
            step(($urandom % 4) != 0, op, rq, 5'($urandom), src);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule